// File: doc/BRIEF.md
# Packed-BCD Decimal Adjust Unit

This block corrects an 8-bit accumulator value after a binary addition of two packed-BCD operands so that the byte again holds two valid decimal digits. It takes the accumulator, the incoming half-carry flag and the incoming carry flag, decides from the original byte which nibble corrections apply, and produces the corrected byte together with the new half-carry and carry flags.

Both nibble corrections are decided in parallel from the unmodified accumulator. They are combined into one correction word, and that word is added to the accumulator in a registered adder. A one-cycle start strobe samples the operands. The result and a one-cycle valid strobe appear two clock cycles later. A new start may be issued on every cycle, and results come out in the order the starts were issued.

Top module: `bcd_adjust_unit`

## Requirements
- R1: The low-nibble correction adds 0x06 when bits [3:0] of the accumulator exceed 9 or hc_i is 1. Otherwise it adds 0x00 to the low nibble.
- R2: The high-nibble correction adds 0x60 when bits [7:4] exceed 9, or cy_i is 1, or bits [7:4] equal 9 while bits [3:0] exceed 9. Otherwise it adds 0x00 to the high nibble.
- R3: Both corrections are decided from the original accumulator in parallel. result_o is (acc_i + correction) modulo 256. Example: 0x9A gives 0x00.
- R4: hc_o is 1 exactly when bits [3:0] of the original accumulator are 10 or more. It does not depend on hc_i.
- R5: cy_o is 1 when any of these holds: cy_i is 1; bits [7:4] are 10 or more; bits [7:4] are 9 or more and bits [3:0] are 10 or more. Otherwise cy_o is 0.
- R6: valid_o is high for exactly one cycle. It goes high two clock edges after the edge that sampled start_i high, and result_o, hc_o and cy_o hold that operation's values in that cycle.
- R7: While rst_ni is low, result_o, hc_o, cy_o and valid_o are 0.
- R8: Starts on consecutive cycles each produce their own result in issue order, one per cycle.
- R9: When no operation completes, result_o, hc_o and cy_o keep their last values and valid_o stays 0, whatever acc_i, hc_i and cy_i do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that samples the operands |
| acc_i | input | 8 | Accumulator value after the binary addition |
| hc_i | input | 1 | Incoming half-carry flag |
| cy_i | input | 1 | Incoming carry flag |
| result_o | output | 8 | Adjusted packed-BCD byte |
| hc_o | output | 1 | New half-carry flag |
| cy_o | output | 1 | New carry flag |
| valid_o | output | 1 | One-cycle strobe marking a completed adjustment |

## Verification
The assertions assume that start_i is a clean, known level at each rising edge. They also assume that acc_i, hc_i and cy_i are known whenever start_i is high. The bench changes every input only on the falling edge. It raises start_i only together with fully defined operands, and it holds start_i low through reset. Random operands are still driven while start_i is low, so that the hold behaviour is exercised without breaking these assumptions.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned BYTE_W  = 2 * NIB_W;
  localparam int unsigned DEC_MAX = 9;
  localparam int unsigned FIX_VAL = 6;

  typedef struct packed {
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W:0]   corr;
    logic              hc;
    logic              cy;
  } adj_op_t;
endpackage

// File: rtl/bcd_adj_decide.sv
module bcd_adj_decide
  import bcd_adj_pkg::*;
#(
  parameter int unsigned NW = NIB_W,
  localparam int unsigned BW = 2 * NW
) (
  input  logic [BW-1:0] acc_i,
  input  logic          hc_i,
  input  logic          cy_i,
  output logic [BW:0]   corr_o,
  output logic          hc_o,
  output logic          cy_o
);
  logic [1:0] gt_max;
  logic [1:0] eq_max;
  logic       low_fix, high_fix;

  for (genvar n = 0; n < 2; n++) begin : g_nib
    logic [NW-1:0] digit;
    assign digit     = acc_i[n*NW +: NW];
    assign gt_max[n] = (digit > NW'(DEC_MAX));
    assign eq_max[n] = (digit == NW'(DEC_MAX));
  end

  // both corrections are taken from the unmodified byte
  assign low_fix  = gt_max[0] | hc_i;
  assign high_fix = gt_max[1] | cy_i | (eq_max[1] & gt_max[0]);

  assign corr_o = {1'b0,
                   (high_fix ? NW'(FIX_VAL) : NW'(0)),
                   (low_fix  ? NW'(FIX_VAL) : NW'(0))};

  assign hc_o = gt_max[0];
  assign cy_o = cy_i | gt_max[1] | ((gt_max[1] | eq_max[1]) & gt_max[0]);

  always_comb begin
    if (hc_i == 1'b1) begin
      a_r1_hc_forces_low_fix: assert (corr_o[NW-1:0] == NW'(FIX_VAL));
    end
    if (cy_i == 1'b1) begin
      a_r2_cy_forces_high_fix: assert (corr_o[2*NW-1:NW] == NW'(FIX_VAL));
    end
  end
endmodule

// File: rtl/bcd_adj_capture.sv
module bcd_adj_capture
  import bcd_adj_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  adj_op_t op_i,
  output adj_op_t op_o,
  output logic    valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o    <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) op_o <= op_i;
    end
  end

  a_r5_cy_in_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i.cy) |=> op_o.cy);
endmodule

// File: rtl/bcd_adj_adder.sv
module bcd_adj_adder
  import bcd_adj_pkg::*;
#(
  parameter int unsigned BW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [BW-1:0] acc_i,
  input  logic [BW:0]   corr_i,
  input  logic          hc_i,
  input  logic          cy_i,
  output logic [BW-1:0] sum_o,
  output logic          hc_o,
  output logic          cy_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o   <= '0;
      hc_o    <= 1'b0;
      cy_o    <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        sum_o <= acc_i + corr_i[BW-1:0];  // truncated to the byte
        hc_o  <= hc_i;
        cy_o  <= cy_i;
      end
    end
  end

  always_comb begin
    if (rst_ni == 1'b1) begin
      a_r3_corr_top_clear: assert (corr_i[BW] !== 1'b1);
    end
  end

  a_r9_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(sum_o) && $stable(hc_o) && $stable(cy_o)));
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adj_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic              hc_i,
  input  logic              cy_i,
  output logic [BYTE_W-1:0] result_o,
  output logic              hc_o,
  output logic              cy_o,
  output logic              valid_o
);
  adj_op_t dec_op, cap_op;
  logic    cap_valid;

  assign dec_op.acc = acc_i;

  bcd_adj_decide #(.NW(NIB_W)) u_decide (
    .acc_i  (acc_i),
    .hc_i   (hc_i),
    .cy_i   (cy_i),
    .corr_o (dec_op.corr),
    .hc_o   (dec_op.hc),
    .cy_o   (dec_op.cy)
  );

  bcd_adj_capture u_capture (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (start_i),
    .op_i    (dec_op),
    .op_o    (cap_op),
    .valid_o (cap_valid)
  );

  bcd_adj_adder #(.BW(BYTE_W)) u_adder (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cap_valid),
    .acc_i   (cap_op.acc),
    .corr_i  (cap_op.corr),
    .hc_i    (cap_op.hc),
    .cy_i    (cap_op.cy),
    .sum_o   (result_o),
    .hc_o    (hc_o),
    .cy_o    (cy_o),
    .valid_o (valid_o)
  );

  a_r6_valid_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ##2 valid_o);
  a_r6_valid_has_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(start_i, 2));
  a_r4_hc_needs_low_digit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && acc_i[NIB_W-1:0] <= NIB_W'(DEC_MAX)) |-> ##2 !hc_o);
endmodule

// File: tb/bcd_adjust_unit_tb.sv
module bcd_adjust_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;
  localparam int BURST      = 48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] acc = 8'h00;
  logic       hc = 1'b0, cy = 1'b0;
  logic [7:0] result;
  logic       hc_out, cy_out, valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_adjust_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .acc_i(acc),
    .hc_i(hc), .cy_i(cy), .result_o(result), .hc_o(hc_out),
    .cy_o(cy_out), .valid_o(valid)
  );

  // reference: {result, hc, cy}
  function automatic logic [9:0] ref_adj(input logic [7:0] a, input logic h, input logic c);
    int lo = a[3:0];
    int hi = a[7:4];
    int add = 0;
    logic [7:0] r;
    logic nh, nc;
    if (lo > 9 || h) add += 6;
    if (hi > 9 || c || (hi == 9 && lo > 9)) add += 96;
    r  = 8'((int'(a) + add) % 256);
    nh = (lo >= 10);
    nc = c || (hi >= 10) || (hi >= 9 && lo >= 10);
    return {r, nh, nc};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [9:0] e);
    check({req, " result"}, 32'(result), 32'(e[9:2]));
    check("R4 hc", 32'(hc_out), 32'(e[1]));
    check("R5 cy", 32'(cy_out), 32'(e[0]));
  endtask

  // one isolated operation, checked in the valid cycle and the one after
  task automatic single_op(input logic [7:0] a, input logic h, input logic c, input string req);
    logic [9:0] e;
    e = ref_adj(a, h, c);
    @(negedge clk); start = 1'b1; acc = a; hc = h; cy = c;
    @(negedge clk); start = 1'b0; acc = $urandom; hc = $urandom; cy = $urandom;
    check("R6 valid low one cycle after start", 32'(valid), 0);
    @(negedge clk);
    check("R6 valid high two cycles after start", 32'(valid), 1);
    check_out(req, e);
    @(negedge clk);
    check("R6 valid single cycle", 32'(valid), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R7 reset result", 32'(result), 0);
    check("R7 reset flags/valid", {29'd0, hc_out, cy_out, valid}, 0);
    rst_n = 1'b1;

    // directed corners
    single_op(8'h00, 1'b1, 1'b0, "R1 hc forces +06");
    single_op(8'h0B, 1'b0, 1'b0, "R1 low digit > 9");
    single_op(8'h00, 1'b0, 1'b1, "R2 cy forces +60");
    single_op(8'hA0, 1'b0, 1'b0, "R2 high digit > 9");
    single_op(8'h9A, 1'b0, 1'b0, "R3 parallel 9A->00");
    single_op(8'h99, 1'b0, 1'b0, "R2 99 untouched");
    single_op(8'hFF, 1'b1, 1'b1, "R3 wrap FF");

    // R9: idle cycles with toggling inputs keep outputs
    begin
      logic [9:0] e = ref_adj(8'hFF, 1'b1, 1'b1);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); acc = $urandom; hc = $urandom; cy = $urandom;
        check("R9 valid stays low", 32'(valid), 0);
        check_out("R9 hold", e);
      end
    end

    // exhaustive sweep
    for (int f = 0; f < 4; f++)
      for (int a = 0; a < 256; a++)
        single_op(8'(a), f[1], f[0], "R3 sweep");

    // R8: back-to-back random burst
    begin
      logic [9:0] exp_q [BURST];
      for (int i = 0; i < BURST + 2; i++) begin
        @(negedge clk);
        if (i >= 2) begin
          check("R8 burst valid", 32'(valid), 1);
          check_out("R8 burst", exp_q[i-2]);
        end
        if (i < BURST) begin
          start = 1'b1; acc = $urandom; hc = $urandom; cy = $urandom;
          exp_q[i] = ref_adj(acc, hc, cy);
        end else begin
          start = 1'b0;
        end
      end
      @(negedge clk);
      check("R8 burst end valid low", 32'(valid), 0);
    end

    // R7: asynchronous reset clears a held result
    single_op(8'h5C, 1'b0, 1'b0, "R3 before reset");
    rst_n = 1'b0;
    #1;
    check("R7 reset clears result", 32'(result), 0);
    check("R7 reset clears flags", {30'd0, hc_out, cy_out}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule